// File: doc/BRIEF.md
# SPI Port with Word-Level Request Handshake

This block is a serial peripheral port that runs either as the SPI master or as an SPI slave, chosen by a mode input. Words are exchanged most significant bit first in SPI mode 0: data is sampled on the rising SCK edge and changed on the falling edge. As master it generates SCK from the system clock through a programmable divider. As slave it passes the external SCK and slave-select through two-flop synchronizers before it looks for edges.

Every word is paced by an active-low request line. A slave drives this line low once a word has been queued and it is ready to transfer. It releases the line on the first SCK edge of that word. A master samples the line, starts a word only when the line is low, and must see it released and then asserted again before it starts the next word. A slave-select seen low while the port is master is reported as a sticky bus error, and that error holds off further master transfers.

The parallel side is a plain register interface: a transmit word with a write strobe, the received word with a one-cycle valid pulse, full and overrun status, and the bus-error flag with its clear. Tri-state pins are modelled as separate output-enable signals.

Top module: `spi_hreq_port`

## Requirements
- R1: In master mode the port sends `tx_data_i` on `mosi_o` and assembles the bits sampled from `miso_i` into `rx_data_o`. Both are most significant bit first. `mosi_o` changes only while `sck_o` is low, `miso_i` is sampled on each rising `sck_o`, `sck_o` is low between words, and each SCK half period lasts `clk_div_i`+1 system clocks.
- R2: A master word starts only when all of these hold: a written word is pending, `bus_err_o` is clear, and either `req_en_i` is 2'b00 or the synchronized `hreq_ni` is low. With `req_en_i` = 2'b00 the request line is not consulted at all.
- R3: After a master word has started, the next word waits until `hreq_ni` has been seen high and then low again. A request line held low throughout does not start a second word.
- R4: `bus_err_o` is set when `ss_ni` is low while `master_i` is 1. It stays set until `bus_err_clr_i` is pulsed, and no master word starts while it is set.
- R5: In slave mode, SCK edges are counted only while the synchronized `ss_ni` is low. `ss_ni` going high discards a partial word. `miso_oe_o` is 1 only in slave mode with slave-select low.
- R6: In slave mode `hreq_no` goes low once a word has been written and the port is idle. It returns high on the first rising SCK edge of the next word.
- R7: `hreq_oe_o` is 1 only in slave mode with `req_en_i` not equal to 2'b00. It is 0 during reset.
- R8: Each completed word raises `rx_valid_o` for exactly one cycle, updates `rx_data_o` and sets `rx_full_o`. A pulse on `rx_read_i` clears `rx_full_o`.
- R9: If a word completes while `rx_full_o` is set and `rx_read_i` is not pulsed in that cycle, `overrun_o` is set. A pulse on `rx_read_i` clears it.
- R10: After reset the outputs are: `sck_o`, `busy_o`, `bus_err_o`, `rx_full_o`, `overrun_o`, `rx_valid_o` and `miso_oe_o` all 0, and `hreq_no` 1.
- R11: In slave mode the word written to `tx_data_i` is shifted out on `miso_o` most significant bit first, changing after falling SCK edges. The bits taken from `mosi_i` on rising edges form `rx_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode |
| req_en_i | input | 2 | Request line enable field; 2'b00 disables the request line |
| clk_div_i | input | DIV_W | SCK half period minus one, in system clocks |
| tx_data_i | input | DATA_W | Word to transmit |
| tx_wr_i | input | 1 | Write strobe for tx_data_i |
| rx_data_o | output | DATA_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when a word completes |
| rx_read_i | input | 1 | Acknowledges that the received word was read |
| rx_full_o | output | 1 | Received word not yet read |
| overrun_o | output | 1 | A word was lost to an unread one |
| busy_o | output | 1 | Word transfer in progress |
| bus_err_o | output | 1 | Sticky bus-error flag |
| bus_err_clr_i | input | 1 | Clears bus_err_o |
| sck_i | input | 1 | Serial clock in slave mode |
| sck_o | output | 1 | Serial clock in master mode |
| sck_oe_o | output | 1 | Output enable for sck_o |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe_o | output | 1 | Output enable for miso_o |
| hreq_ni | input | 1 | Request line in, master mode, active low |
| hreq_no | output | 1 | Request line out, slave mode, active low |
| hreq_oe_o | output | 1 | Output enable for hreq_no |

## Verification
The hardest state to reach from the ports is a master that has finished a word while the request line is still low. In that state it must hold off, because it has not seen the line released and asserted again. The bench reaches it by turning off the behavioural slave's release of the request line. It then keeps the line low across a whole word, queues a second word, and confirms over a long idle window that nothing starts until it pulses the line high and low. A similar window follows a short slave-select pulse in master mode, to show that the latched bus error alone holds off a pending word. On the slave side, SCK toggling with select high and a word aborted after three bits are both followed by a full word, to confirm that no stray bits leaked into the count.

// File: rtl/spi_hreq_pkg.sv
package spi_hreq_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_ev_t;
endpackage

// File: rtl/spi_hreq_sync.sv
module spi_hreq_sync #(
  parameter int unsigned           WIDTH   = 1,
  parameter int unsigned           STAGES  = 2,
  parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_hreq_sckgen.sv
module spi_hreq_sckgen
  import spi_hreq_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             last_i,
  output logic             sck_o,
  output logic             run_o,
  output sck_ev_t          ev_o
);
  logic [DIV_W-1:0] cnt_q;
  logic sck_q, run_q, fin_q;
  logic tick;

  assign tick    = run_q && (cnt_q == div_i);
  assign ev_o.rise = tick && !sck_q;
  assign ev_o.fall = tick && sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      run_q <= 1'b1;
      fin_q <= 1'b0;
    end else if (run_q) begin
      if (tick) begin
        cnt_q <= '0;
        sck_q <= !sck_q;
        if (!sck_q && last_i) fin_q <= 1'b1;
        // trailing falling edge returns SCK low and ends the word
        if (sck_q && fin_q) begin
          run_q <= 1'b0;
          fin_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sck_o = sck_q;
  assign run_o = run_q;
endmodule

// File: rtl/spi_hreq_shifter.sv
module spi_hreq_shifter
  import spi_hreq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clear_i,
  input  sck_ev_t           ev_i,
  input  logic              in_bit_i,
  output logic              out_bit_o,
  output logic              last_o,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rbit_q, active_q, done_q;

  assign last_o = (cnt_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      rx_q     <= '0;
      cnt_q    <= '0;
      rbit_q   <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        shreg_q  <= load_data_i;
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else if (clear_i) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else if (ev_i.rise) begin
        rbit_q <= in_bit_i;
        if (last_o) begin
          rx_q     <= {shreg_q[DATA_W-2:0], in_bit_i};
          done_q   <= 1'b1;
          cnt_q    <= '0;
          active_q <= 1'b0;
        end else begin
          cnt_q    <= cnt_q + 1'b1;
          active_q <= 1'b1;
        end
      end else if (ev_i.fall && active_q) begin
        shreg_q <= {shreg_q[DATA_W-2:0], rbit_q};
      end
    end
  end

  assign out_bit_o = shreg_q[DATA_W-1];
  assign active_o  = active_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_q;
endmodule

// File: rtl/spi_hreq_port.sv
module spi_hreq_port
  import spi_hreq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [1:0]        req_en_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_read_i,
  output logic              rx_full_o,
  output logic              overrun_o,
  output logic              busy_o,
  output logic              bus_err_o,
  input  logic              bus_err_clr_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              hreq_ni,
  output logic              hreq_no,
  output logic              hreq_oe_o
);
  logic              sck_s, ss_s, hreq_s, sck_d_q;
  logic              ss_act, s_rise, s_fall;
  sck_ev_t           m_ev, ev;
  logic              m_run, m_start, s_arm, load, clear;
  logic              sh_out, sh_last, sh_active, sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic [DATA_W-1:0] tx_buf_q;
  logic              tx_pend_q, armed_q, seen_hi_q, bus_err_q;
  logic              rx_full_q, overrun_q, hreq_oe_q;
  logic              req_on, hreq_ok;

  spi_hreq_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({hreq_ni, ss_ni, sck_i}),
    .q_o    ({hreq_s, ss_s, sck_s})
  );

  assign ss_act = !ss_s;
  assign s_rise = sck_s && !sck_d_q;
  assign s_fall = !sck_s && sck_d_q;
  assign req_on = (req_en_i != 2'b00);
  assign hreq_ok = !req_on || (!hreq_s && seen_hi_q);

  assign m_start = master_i && !m_run && !bus_err_q && tx_pend_q && hreq_ok;

  always_comb begin
    if (master_i) begin
      ev = m_ev;
    end else begin
      ev.rise = s_rise && ss_act;
      ev.fall = s_fall && ss_act;
    end
  end

  // slave arms only while idle; a concurrent edge wins
  assign s_arm = !master_i && !armed_q && !sh_active && tx_pend_q && !ev.rise;
  assign load  = m_start || s_arm;
  assign clear = !master_i && !ss_act;

  spi_hreq_sckgen #(.DIV_W(DIV_W)) u_sckgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (m_start),
    .div_i   (clk_div_i),
    .last_i  (sh_last),
    .sck_o   (sck_o),
    .run_o   (m_run),
    .ev_o    (m_ev)
  );

  spi_hreq_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_buf_q),
    .clear_i     (clear),
    .ev_i        (ev),
    .in_bit_i    (master_i ? miso_i : mosi_i),
    .out_bit_o   (sh_out),
    .last_o      (sh_last),
    .active_o    (sh_active),
    .done_o      (sh_done),
    .rx_word_o   (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q   <= 1'b0;
      tx_buf_q  <= '0;
      tx_pend_q <= 1'b0;
      armed_q   <= 1'b0;
      seen_hi_q <= 1'b1;
      bus_err_q <= 1'b0;
      rx_full_q <= 1'b0;
      overrun_q <= 1'b0;
      hreq_oe_q <= 1'b0;
    end else begin
      sck_d_q   <= sck_s;
      hreq_oe_q <= !master_i && req_on;

      if (tx_wr_i) begin
        tx_buf_q  <= tx_data_i;
        tx_pend_q <= 1'b1;
      end else if (load) begin
        tx_pend_q <= 1'b0;
      end

      if (master_i)      armed_q <= 1'b0;
      else if (s_arm)    armed_q <= 1'b1;
      else if (ev.rise)  armed_q <= 1'b0;

      if (m_start)       seen_hi_q <= 1'b0;
      else if (hreq_s)   seen_hi_q <= 1'b1;

      if (master_i && ss_act) bus_err_q <= 1'b1;
      else if (bus_err_clr_i) bus_err_q <= 1'b0;

      if (sh_done)        rx_full_q <= 1'b1;
      else if (rx_read_i) rx_full_q <= 1'b0;

      if (sh_done && rx_full_q && !rx_read_i) overrun_q <= 1'b1;
      else if (rx_read_i)                     overrun_q <= 1'b0;
    end
  end

  assign rx_data_o  = sh_rx;
  assign rx_valid_o = sh_done;
  assign rx_full_o  = rx_full_q;
  assign overrun_o  = overrun_q;
  assign busy_o     = master_i ? m_run : sh_active;
  assign bus_err_o  = bus_err_q;
  assign sck_oe_o   = master_i;
  assign mosi_o     = sh_out;
  assign miso_o     = sh_out;
  assign miso_oe_o  = !master_i && ss_act;
  assign hreq_no    = !armed_q;
  assign hreq_oe_o  = hreq_oe_q;
endmodule

// File: rtl/spi_hreq_port_chk.sv
module spi_hreq_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       master_i,
  input logic [1:0] req_en_i,
  input logic       ss_ni,
  input logic       bus_err_clr_i,
  input logic       busy_o,
  input logic       bus_err_o,
  input logic       rx_valid_o,
  input logic       miso_oe_o,
  input logic       hreq_no,
  input logic       hreq_oe_o
);
  // R4
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o && !bus_err_clr_i |=> bus_err_o);

  // R4
  no_start_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && $rose(busy_o) |-> !$past(bus_err_o));

  // R8
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R5
  miso_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ss_ni, 2) && $past(ss_ni) |-> !miso_oe_o);

  // R7
  hreq_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_oe_o |-> !$past(master_i) && ($past(req_en_i) != 2'b00));

  // R6
  hreq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i && !$past(master_i) && $rose(busy_o) |-> hreq_no);
endmodule

bind spi_hreq_port spi_hreq_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .master_i      (master_i),
  .req_en_i      (req_en_i),
  .ss_ni         (ss_ni),
  .bus_err_clr_i (bus_err_clr_i),
  .busy_o        (busy_o),
  .bus_err_o     (bus_err_o),
  .rx_valid_o    (rx_valid_o),
  .miso_oe_o     (miso_oe_o),
  .hreq_no       (hreq_no),
  .hreq_oe_o     (hreq_oe_o)
);

// File: tb/spi_hreq_port_bench.sv
module spi_hreq_port_bench;
  localparam int CLK_P = 10;
  localparam int H     = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       master_i = 1'b0;
  logic [1:0] req_en_i = 2'b01;
  logic [7:0] clk_div_i = 8'd0;
  logic [7:0] tx_data_i = 8'd0;
  logic       tx_wr_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_valid_o, rx_read_i = 1'b0, rx_full_o, overrun_o, busy_o;
  logic       bus_err_o, bus_err_clr_i = 1'b0;
  logic       sck_i = 1'b0, sck_o, sck_oe_o, ss_ni = 1'b1;
  logic       mosi_i = 1'b0, mosi_o, miso_i, miso_o, miso_oe_o;
  logic       hreq_ni, hreq_no, hreq_oe_o;

  int total = 0, bad = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = 8'd0;

  // behavioural slave for master-mode runs
  logic       hreq_drv = 1'b1, raise_en = 1'b1, mdl_hi = 1'b0, msck_prev = 1'b0;
  logic [7:0] mdl_in = 8'd0, mword = 8'd0, cap = 8'd0;
  int         mdl_seq = 0, seen_seq = 0, ncap = 0;

  assign hreq_ni = hreq_drv | (raise_en & mdl_hi);

  always #(CLK_P/2) clk = ~clk;

  spi_hreq_port u_spi_hreq_port (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .req_en_i(req_en_i),
    .clk_div_i(clk_div_i), .tx_data_i(tx_data_i), .tx_wr_i(tx_wr_i),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_read_i(rx_read_i),
    .rx_full_o(rx_full_o), .overrun_o(overrun_o), .busy_o(busy_o),
    .bus_err_o(bus_err_o), .bus_err_clr_i(bus_err_clr_i), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .ss_ni(ss_ni), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .hreq_ni(hreq_ni), .hreq_no(hreq_no), .hreq_oe_o(hreq_oe_o)
  );

  always @(negedge clk) begin
    if (rst_ni && rx_valid_o) begin
      rx_cnt  = rx_cnt + 1;
      rx_last = rx_data_o;
    end
  end

  initial miso_i = 1'b0;
  always @(negedge clk) begin
    if (seen_seq != mdl_seq) begin
      seen_seq = mdl_seq;
      mword = mdl_in;
      miso_i = mdl_in[7];
      cap = 8'd0;
      ncap = 0;
      mdl_hi = 1'b0;
    end else begin
      if (sck_o && !msck_prev) begin
        cap = {cap[6:0], mosi_o};
        ncap = ncap + 1;
        if (ncap == 1) mdl_hi = 1'b1;
      end
      if (!sck_o && msck_prev) begin
        mword = {mword[6:0], 1'b0};
        miso_i = mword[7];
      end
    end
    msck_prev = sck_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_wr(input logic [7:0] v);
    @(negedge clk);
    tx_data_i = v;
    tx_wr_i = 1'b1;
    @(negedge clk);
    tx_wr_i = 1'b0;
  endtask

  task automatic rx_rd();
    @(negedge clk);
    rx_read_i = 1'b1;
    @(negedge clk);
    rx_read_i = 1'b0;
  endtask

  task automatic wait_rx(input int target, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (rx_cnt >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
    tick(2);
  endtask

  // prime the behavioural slave and pull the request line low
  task automatic prime(input logic [7:0] sl);
    mdl_in = sl;
    mdl_seq = mdl_seq + 1;
    hreq_drv = 1'b0;
    tick(2);
  endtask

  task automatic s_word(input logic [7:0] mo, input int nbits, output logic [7:0] mi,
                        output logic hmid, output logic oemid);
    logic [7:0] got;
    got = 8'd0;
    hmid = 1'b0;
    oemid = 1'b0;
    ss_ni = 1'b0;
    tick(4);
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi_i = mo[b];
      tick(H);
      got[b] = miso_o;
      sck_i = 1'b1;
      tick(H);
      if (b == 7) begin
        hmid = hreq_no;
        oemid = miso_oe_o;
      end
      sck_i = 1'b0;
    end
    tick(H);
    ss_ni = 1'b1;
    tick(4);
    mi = got;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] t, s, mi;
    logic hm, oe;
    int n0;
    void'($urandom(32'd4711));

    tick(3);
    chk("R7 oe in reset", hreq_oe_o, 0);
    chk("R10 miso_oe in reset", miso_oe_o, 0);
    rst_ni = 1'b1;
    tick(4);
    chk("R10 sck_o", sck_o, 0);
    chk("R10 busy", busy_o, 0);
    chk("R10 bus_err", bus_err_o, 0);
    chk("R10 rx_full", rx_full_o, 0);
    chk("R10 overrun", overrun_o, 0);
    chk("R10 hreq_no", hreq_no, 1);
    chk("R7 oe slave enabled", hreq_oe_o, 1);
    req_en_i = 2'b00;
    tick(2);
    chk("R7 oe field clear", hreq_oe_o, 0);
    req_en_i = 2'b10;
    tick(2);
    chk("R7 oe other bit", hreq_oe_o, 1);

    // slave words
    req_en_i = 2'b01;
    for (int k = 0; k < 8; k++) begin
      t = 8'($urandom);
      s = 8'($urandom);
      if (k == 0) begin t = 8'h80; s = 8'h01; end
      if (k == 1) begin t = 8'hFF; s = 8'h00; end
      n0 = rx_cnt;
      tx_wr(t);
      tick(4);
      chk("R6 hreq low when ready", hreq_no, 0);
      s_word(s, 8, mi, hm, oe);
      chk("R11 miso word", mi, t);
      chk("R11 rx word", rx_last, s);
      chk("R8 one word", rx_cnt - n0, 1);
      chk("R6 hreq released", hm, 1);
      chk("R5 miso_oe while selected", oe, 1);
      chk("R8 rx_full set", rx_full_o, 1);
      rx_rd();
      chk("R8 rx_full cleared", rx_full_o, 0);
    end

    // SCK with select high is ignored
    t = 8'hA5;
    tx_wr(t);
    tick(4);
    n0 = rx_cnt;
    for (int i = 0; i < 10; i++) begin
      sck_i = 1'b1; tick(H);
      if (i == 3) chk("R5 miso_oe deselected", miso_oe_o, 0);
      sck_i = 1'b0; tick(H);
    end
    chk("R5 no word deselected", rx_cnt - n0, 0);
    chk("R6 still armed", hreq_no, 0);
    s_word(8'h3C, 8, mi, hm, oe);
    chk("R5 word after stray edges", rx_last, 8'h3C);
    chk("R11 miso after stray edges", mi, t);
    rx_rd();

    // aborted partial word
    n0 = rx_cnt;
    s_word(8'hF0, 3, mi, hm, oe);
    chk("R5 abort gives no word", rx_cnt - n0, 0);
    tx_wr(8'h5A);
    tick(4);
    s_word(8'h96, 8, mi, hm, oe);
    chk("R5 full word after abort", rx_last, 8'h96);
    chk("R11 miso after abort", mi, 8'h5A);

    // overrun: previous word unread
    s_word(8'h11, 8, mi, hm, oe);
    chk("R9 overrun set", overrun_o, 1);
    chk("R9 newest kept", rx_last, 8'h11);
    rx_rd();
    chk("R9 overrun cleared", overrun_o, 0);
    chk("R8 full cleared", rx_full_o, 0);

    // master words
    master_i = 1'b1;
    tick(4);
    chk("R7 oe master", hreq_oe_o, 0);
    for (int k = 0; k < 16; k++) begin
      t = 8'($urandom);
      s = 8'($urandom);
      clk_div_i = 8'($urandom_range(0, 3));
      prime(s);
      n0 = rx_cnt;
      tx_wr(t);
      wait_rx(n0 + 1, 3000);
      chk("R1 master rx word", rx_last, s);
      chk("R1 master mosi word", cap, t);
      wait_idle();
      chk("R1 sck idle low", sck_o, 0);
      rx_rd();
    end

    // no second word without re-assertion
    clk_div_i = 8'd1;
    raise_en = 1'b0;
    hreq_drv = 1'b1;
    tick(4);
    prime(8'hC3);
    n0 = rx_cnt;
    tx_wr(8'h81);
    wait_rx(n0 + 1, 3000);
    chk("R3 first word", rx_last, 8'hC3);
    wait_idle();
    rx_rd();
    prime(8'h7E);
    tx_wr(8'h42);
    tick(120);
    chk("R3 held off", rx_cnt - n0, 1);
    chk("R3 not busy", busy_o, 0);
    hreq_drv = 1'b1;
    tick(4);
    hreq_drv = 1'b0;
    wait_rx(n0 + 2, 3000);
    chk("R3 resumes", rx_last, 8'h7E);
    chk("R3 mosi", cap, 8'h42);
    wait_idle();
    rx_rd();
    raise_en = 1'b1;

    // request line high: no start
    hreq_drv = 1'b1;
    n0 = rx_cnt;
    mdl_in = 8'h99;
    mdl_seq = mdl_seq + 1;
    tick(2);
    hreq_drv = 1'b1;
    tx_wr(8'h24);
    tick(80);
    chk("R2 waits for request", rx_cnt - n0, 0);
    hreq_drv = 1'b0;
    wait_rx(n0 + 1, 3000);
    chk("R2 starts on request", rx_last, 8'h99);
    wait_idle();
    rx_rd();

    // request field cleared: line ignored
    req_en_i = 2'b00;
    hreq_drv = 1'b1;
    mdl_in = 8'h5C;
    mdl_seq = mdl_seq + 1;
    tick(2);
    hreq_drv = 1'b1;
    n0 = rx_cnt;
    tx_wr(8'hE7);
    wait_rx(n0 + 1, 3000);
    chk("R2 no request needed", rx_last, 8'h5C);
    chk("R2 mosi", cap, 8'hE7);
    wait_idle();
    rx_rd();
    req_en_i = 2'b01;

    // bus error
    hreq_drv = 1'b1;
    tick(4);
    ss_ni = 1'b0;
    tick(3);
    ss_ni = 1'b1;
    tick(4);
    chk("R4 bus error set", bus_err_o, 1);
    prime(8'h3A);
    n0 = rx_cnt;
    tx_wr(8'hB4);
    tick(100);
    chk("R4 start blocked", rx_cnt - n0, 0);
    chk("R4 still set", bus_err_o, 1);
    @(negedge clk); bus_err_clr_i = 1'b1;
    @(negedge clk); bus_err_clr_i = 1'b0;
    chk("R4 cleared", bus_err_o, 0);
    wait_rx(n0 + 1, 3000);
    chk("R4 word after clear", rx_last, 8'h3A);
    chk("R4 mosi after clear", cap, 8'hB4);
    wait_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule